// File: doc/BRIEF.md
# Processor Reset Sequencer

This block generates the reset line for a processor from three sources: a flag showing the main supply is good, a flag showing an auxiliary supply is good, and an active-low push button. Reset is held while any of these sources calls for it. Once all of them are quiet, reset is held for a further timeout. A 3-bit code picks the length of that timeout. All three inputs are asynchronous and pass through synchronizers. The button also passes through a glitch filter that runs at the system clock rate.

A dual-timeout mode makes the hold time depend on what caused the reset. A reset caused by a supply uses a long hold. A reset caused only by the button uses a short one. The same reset state appears on three outputs: an active-low line, an active-high line, and a pull-down enable for an open-drain driver. A 1 µs tick comes from a prescaler set by the clock frequency parameter. A second parameter scales how many ticks make one millisecond, so the timeouts can be shortened for simulation.

Top module: `supv_reset_seq`

## Requirements
- R1: Reset is asserted whenever main_ok_i is low, aux_ok_i is low, or the filtered button request is active. Each input reaches the logic two cycles late because of its synchronizer.
- R2: After the last cause clears, reset stays asserted for exactly timeout × CLK_HZ/1e6 × TICK_PER_MS cycles, plus the synchronizer and filter latency. Then it releases.
- R3: If any cause returns during the countdown, the count is cleared. A full timeout is then counted again from the moment that cause clears.
- R4: With dual_tmo_i low, tmo_sel_i selects the timeout in ms: 0→1, 1→1, 2→20, 3→140, 5→280, 6→560, 4→1120, 7→1200.
- R5: The button is accepted only after it has been seen low for FILT_NS worth of consecutive clock cycles. Shorter low pulses leave reset untouched. A low level of 1 µs or more is always accepted.
- R6: With dual_tmo_i high, code 4 gives 1120 ms for a supply-caused reset and 140 ms for a reset caused by the button alone. Code 7 gives 1200 ms and 150 ms. If a supply cause occurred at any point in the episode, the long value is used.
- R7: With dual_tmo_i high, any code other than 4 or 7 uses the code-4 values.
- R8: While reset is asserted, rst_no is 0, rst_o is 1 and od_pd_en_o is 1. While reset is released, the three outputs take the opposite values.
- R9: Reset is asserted during the asynchronous reset and runs a full supply-type timeout after it is removed. That is the long value in dual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| main_ok_i | input | 1 | Main supply above its threshold (async) |
| aux_ok_i | input | 1 | Auxiliary supply above its threshold (async) |
| mr_ni | input | 1 | Manual reset button, active low (async) |
| tmo_sel_i | input | 3 | Timeout code (static strap) |
| dual_tmo_i | input | 1 | Selects separate supply and button timeouts |
| rst_no | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| od_pd_en_o | output | 1 | Pull-down enable for an open-drain reset pin |

## Verification
The bench measures the release cycle for every code. This includes the out-of-order code 4 and the unlisted code 0, so a decoder that sorts the codes or lets code 0 fall through shows a wrong count. It drops a supply in the middle of a countdown, which catches a counter that resumes instead of restarting and so releases early. Button pulses on either side of the filter window catch a filter that is missing or too slow. In dual mode, a reset caused by both button and supply must take the long hold. A design that keeps only the most recent cause would release after the short hold. Illegal codes must fall back to the code-4 timing.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned MAX_MS = 1200;

  // timeout in ms; dual mode splits supply vs button-only episodes
  function automatic int unsigned tmo_ms(input logic [2:0] sel, input logic dual,
                                         input logic sup);
    int unsigned ms;
    if (dual) begin
      if (sel == 3'd7) ms = sup ? 1200 : 150;
      else             ms = sup ? 1120 : 140;
    end else begin
      case (sel)
        3'd2:    ms = 20;
        3'd3:    ms = 140;
        3'd4:    ms = 1120;
        3'd5:    ms = 280;
        3'd6:    ms = 560;
        3'd7:    ms = 1200;
        default: ms = 1;
      endcase
    end
    return ms;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/supv_tick.sv
module supv_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  if (DIV <= 1) begin : g_pass
    assign tick_o = !clr_i;
  end else begin : g_div
    localparam int unsigned PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    logic [PW-1:0] pcnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            pcnt <= '0;
      else if (clr_i)         pcnt <= '0;
      else if (pcnt == LAST)  pcnt <= '0;
      else                    pcnt <= pcnt + 1'b1;
    end
    assign tick_o = !clr_i && (pcnt == LAST);

    p_tick_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/supv_deglitch.sv
module supv_deglitch #(
  parameter int unsigned WIN = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_s_i,   // synchronized, active low
  output logic req_o
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);
  logic [CW-1:0] lcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcnt  <= '0;
      req_o <= 1'b0;
    end else if (in_s_i) begin
      lcnt  <= '0;
      req_o <= 1'b0;
    end else if (!req_o) begin
      if (lcnt == LAST) req_o <= 1'b1;
      else              lcnt  <= lcnt + 1'b1;
    end
  end

  p_req_after_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(!in_s_i));
  p_req_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_s_i |=> !req_o);
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned TICK_PER_MS = 1000,
  parameter int unsigned FILT_NS     = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_ok_i,
  input  logic       aux_ok_i,
  input  logic       mr_ni,
  input  logic [2:0] tmo_sel_i,
  input  logic       dual_tmo_i,
  output logic       rst_no,
  output logic       rst_o,
  output logic       od_pd_en_o
);
  localparam int unsigned CLK_PER_US = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned FILT_RAW   = (FILT_NS * CLK_PER_US + 999) / 1000;
  localparam int unsigned FILT_CYC   = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int unsigned CNT_W      = $clog2(MAX_MS * TICK_PER_MS + 1);

  logic [2:0] in_s;
  logic       main_s, aux_s, mr_s, mr_req;
  logic       cause, sup_cause, tick;
  logic       act, sup_seen;
  logic [CNT_W-1:0] cnt, limit;
  logic [31:0]      lim32;

  supv_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({mr_ni, aux_ok_i, main_ok_i}),
    .q_o (in_s)
  );
  assign main_s = in_s[0];
  assign aux_s  = in_s[1];
  assign mr_s   = in_s[2];

  supv_deglitch #(.WIN(FILT_CYC)) u_filt (
    .clk_i, .rst_ni, .in_s_i(mr_s), .req_o(mr_req)
  );

  assign sup_cause = !main_s || !aux_s;
  assign cause     = sup_cause || mr_req;

  supv_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk_i, .rst_ni, .clr_i(cause || !act), .tick_o(tick)
  );

  assign lim32 = tmo_ms(tmo_sel_i, dual_tmo_i, sup_seen) * TICK_PER_MS;
  assign limit = lim32[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act      <= 1'b1;
      cnt      <= '0;
      sup_seen <= 1'b1;   // power-up counts as a supply episode
    end else if (cause) begin
      act <= 1'b1;
      cnt <= '0;
      if (sup_cause) sup_seen <= 1'b1;
    end else if (act && tick) begin
      if (cnt >= limit - 1'b1) begin
        act      <= 1'b0;
        cnt      <= '0;
        sup_seen <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rst_o      = act;
  assign rst_no     = !act;
  assign od_pd_en_o = act;

  p_cause_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause |=> rst_o);
  p_release_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act) |-> $past(!cause && tick));
  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause |=> (cnt == '0));
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> (cnt < limit));
  p_sup_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause && sup_cause) |=> sup_seen);
endmodule

// File: tb/supv_reset_seq_bench.sv
module supv_reset_seq_bench;
  localparam int CPM = 10;  // cycles per ms at 10 cycles/us, 1 tick/ms

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b1, aux_ok = 1'b1, mr_n = 1'b1;
  logic [2:0] sel = 3'd1;
  logic       dual = 1'b0;
  logic       rst_no, rst_o, od_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  supv_reset_seq #(.CLK_HZ(10_000_000), .TICK_PER_MS(1), .FILT_NS(500)) u_supv_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .main_ok_i(main_ok), .aux_ok_i(aux_ok), .mr_ni(mr_n),
    .tmo_sel_i(sel), .dual_tmo_i(dual), .rst_no(rst_no), .rst_o(rst_o), .od_pd_en_o(od_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R8: all three outputs agree with expected reset state
  task automatic chk_outs(input bit exp_act, input string req);
    chk(rst_o == exp_act && rst_no == !exp_act && od_en == exp_act,
        {req, " R8"}, {rst_no, rst_o, od_en}, {!exp_act, exp_act, exp_act});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count cycles from now until release, expect [ms*CPM, ms*CPM+6]
  task automatic measure(input int ms, input string req);
    int n = 0;
    int t = ms * CPM;
    while (rst_o && n < t + 50) begin
      @(negedge clk);
      n++;
    end
    chk(n >= t && n <= t + 6, req, n, t);
    chk_outs(1'b0, req);
  endtask

  task automatic supply_pulse(input int ms, input string req);
    main_ok = 1'b0;
    cyc(5);
    chk_outs(1'b1, {req, " R1"});
    main_ok = 1'b1;
    measure(ms, req);
  endtask

  task automatic button_press(input int len);
    mr_n = 1'b0;
    cyc(len);
    mr_n = 1'b1;
  endtask

  task automatic t_power_up();
    cyc(3);
    chk_outs(1'b1, "R9 in reset");
    rst_n = 1'b1;
    measure(1, "R9 power-up code1");
  endtask

  task automatic t_codes();
    int codes[8] = '{1, 2, 3, 5, 6, 4, 7, 0};
    int ms[8]    = '{1, 20, 140, 280, 560, 1120, 1200, 1};
    for (int i = 0; i < 8; i++) begin
      sel = 3'(codes[i]);
      supply_pulse(ms[i], $sformatf("R4 code %0d", codes[i]));
    end
  endtask

  task automatic t_aux_hold();
    bit held = 1;
    sel = 3'd2;
    aux_ok = 1'b0;
    cyc(3);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!rst_o) held = 0;
    end
    chk(held, "R1 aux held", held, 1);
    aux_ok = 1'b1;
    measure(20, "R2 aux release");
  endtask

  task automatic t_restart();
    sel = 3'd3;
    main_ok = 1'b0;
    cyc(5);
    main_ok = 1'b1;
    cyc(700);
    chk_outs(1'b1, "R3 mid count");
    aux_ok = 1'b0;
    cyc(4);
    aux_ok = 1'b1;
    cyc(800);
    chk_outs(1'b1, "R3 past first deadline");
    measure(140 - 80, "R3 restart");
  endtask

  task automatic t_glitch();
    bit quiet = 1;
    sel = 3'd1;
    button_press(3);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_o) quiet = 0;
    end
    chk(quiet, "R5 short pulse ignored", !quiet, 0);
    button_press(4);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rst_o) quiet = 0;
    end
    chk(quiet, "R5 sub-window pulse ignored", !quiet, 0);
    mr_n = 1'b0;
    cyc(10);
    chk_outs(1'b1, "R5 1us press accepted");
    mr_n = 1'b1;
    measure(1, "R5 button release");
  endtask

  task automatic t_dual();
    dual = 1'b1;
    sel = 3'd4;
    supply_pulse(1120, "R6 dual code4 supply");
    button_press(12);
    measure(140, "R6 dual code4 button");
    sel = 3'd7;
    button_press(12);
    measure(150, "R6 dual code7 button");
    mr_n = 1'b0;
    cyc(12);
    aux_ok = 1'b0;
    cyc(5);
    aux_ok = 1'b1;
    mr_n = 1'b1;
    measure(1200, "R6 dual both causes");
    sel = 3'd2;
    button_press(12);
    measure(140, "R7 dual illegal code");
  endtask

  task automatic t_dual_power_up();
    sel = 3'd7;
    dual = 1'b1;
    rst_n = 1'b0;
    cyc(3);
    chk_outs(1'b1, "R9 dual in reset");
    rst_n = 1'b1;
    measure(1200, "R9 dual power-up");
  endtask

  initial begin
    t_power_up();
    t_codes();
    t_aux_hold();
    t_restart();
    t_glitch();
    t_dual();
    t_dual_power_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule